// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit timer that counts up freely at a rate chosen by a prescaler and cannot be loaded by software. Three input channels sample external pins and, on a chosen transition, record the current count into their own 16-bit register. Five output channels each hold a 16-bit target. When the counter reaches a target, the channel raises a flag and can drive its output pin automatically.

The same clock chain also produces a periodic real-time tick at one of four rates. The counter sets an overflow flag each time it wraps. Every function has a flag and an enable, and drives its own interrupt line. Software reaches all of this through a single-cycle register port. Register reads are combinational. Register writes take effect on the next clock edge.

Top module: `tmr_capcmp`

## Requirements
- R1: The counter at address 0 resets to 0 and advances by one on each prescaled tick, wrapping from 0xFFFF to 0x0000. It holds its value between ticks, and a write to address 0 leaves it unchanged.
- R2: Control register bits [1:0] (address 11) choose the tick rate. The code 0 ticks every clock, 1 every 4 clocks, 2 every 8 clocks and 3 every 16 clocks, all taken from a 4-bit free-running divider that resets to 0.
- R3: A tick taken while the counter holds 0xFFFF sets flag bit 8.
- R4: Each capture pin passes through two synchronizing flops before edge detection. When a selected edge is detected, the channel's register (addresses 1 to 3) loads the count held in that cycle, and flag bit c (c = 0..2) is set.
- R5: Edge-select register (address 9), bits [2c+1:2c] for capture channel c: 00 disabled, 01 rising, 10 falling, 11 both edges. A disabled channel keeps its register and its flag unchanged.
- R6: Compare channel k (k = 0..4) has its target at address 4+k, which resets to 0xFFFF. On the clock edge where the counter takes the target value, flag bit 3+k is set.
- R7: Action register (address 10), bits [2k+1:2k] for compare channel k: 00 no action with the disconnect output high, 01 toggle the pin, 10 drive it low, 11 drive it high. Pins reset low and change only on a match.
- R8: The real-time flag (bit 9) is set once every 2^(13+s) clocks, where s is control bits [3:2], counted by a free-running counter that resets to 0.
- R9: Flags (address 12) are cleared by writing 1 to their bit. A new event in the same cycle wins over the clear. The enable register is at address 13 with the same bit layout, and each interrupt line i is high while flag i and enable i are both set.
- R10: All registers read back on the combinational read port. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cap_pin | input | 3 | Capture inputs, asynchronous |
| cmp_pin | output | 5 | Compare output pin levels |
| cmp_hiz | output | 5 | High when a compare pin should be disconnected |
| irq | output | 10 | Per-function interrupt requests |

## Verification
The bench aims at the corner cases where time is counted off by one. A compare target reached only through a wrap to zero would be missed by a design that compares against the current count rather than the next one. Under a divided tick, that same design would fire repeatedly across the whole tick window. The capture path is driven with pulses on each edge selection. A chain one flop short, or one that records the count after the update, gives values off by one, and a disabled channel that still latches shows up as a changed register. Flag clears are issued while events are still arriving, and the real-time period is measured across a change of rate, so a clear that wins over a set, or a wrong tap bit, changes the interrupt lines on some cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {ACT_NONE = 2'b00, ACT_TOGGLE = 2'b01,
                            ACT_CLEAR = 2'b10, ACT_SET = 2'b11} cmp_act_e;

  typedef enum logic [1:0] {EDGE_OFF = 2'b00, EDGE_RISE = 2'b01,
                            EDGE_FALL = 2'b10, EDGE_BOTH = 2'b11} cap_edge_e;

  // divider mask: tick when the low bits of the divider are all ones
  function automatic logic [3:0] presc_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_mask = 4'b0000;
      2'd1:    presc_mask = 4'b0011;
      2'd2:    presc_mask = 4'b0111;
      default: presc_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic apply_act(input cmp_act_e act, input logic cur);
    case (act)
      ACT_TOGGLE: apply_act = ~cur;
      ACT_CLEAR:  apply_act = 1'b0;
      ACT_SET:    apply_act = 1'b1;
      default:    apply_act = cur;
    endcase
  endfunction

  function automatic logic edge_hit(input cap_edge_e sel, input logic now,
                                    input logic prev);
    case (sel)
      EDGE_RISE: edge_hit = now & ~prev;
      EDGE_FALL: edge_hit = ~now & prev;
      EDGE_BOTH: edge_hit = now ^ prev;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RTI_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       psel,
  input  logic [1:0]       rsel,
  output logic             tick,
  output logic             wrap,
  output logic             rti_hit,
  output logic [CNT_W-1:0] count
);
  localparam int RTI_W = RTI_LOG2 + 3;

  logic [3:0]       pdiv_q;
  logic [RTI_W-1:0] rti_q;
  logic [RTI_W-1:0] rmask;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       pmask;

  assign pmask = presc_mask(psel);
  assign tick  = (pdiv_q & pmask) == pmask;
  assign wrap  = tick && (&cnt_q);
  assign count = cnt_q;

  // a shift of RTI_W yields zero, so the top rate becomes all ones
  always_comb rmask = (RTI_W'(1) << (RTI_LOG2 + int'(rsel))) - RTI_W'(1);
  assign rti_hit = (rti_q & rmask) == rmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdiv_q <= '0;
      rti_q  <= '0;
      cnt_q  <= '0;
    end else begin
      pdiv_q <= pdiv_q + 4'd1;
      rti_q  <= rti_q + RTI_W'(1);
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [CNT_W-1:0] cap_val
);
  logic s1_q, s2_q, prev_q;

  assign hit = edge_hit(cap_edge_e'(edge_sel), s2_q, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prev_q  <= 1'b0;
      cap_val <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (hit) cap_val <= count;
    end
  end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] target,
  input  logic [1:0]       act,
  output logic             hit,
  output logic             pin_q,
  output logic             hiz
);
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = count + CNT_W'(1);
  assign hit      = tick && (cnt_next == target);
  assign hiz      = cmp_act_e'(act) == ACT_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n)   pin_q <= 1'b0;
    else if (hit) pin_q <= apply_act(cmp_act_e'(act), pin_q);
  end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int N_CAP    = 3,
  parameter int N_CMP    = 5,
  parameter int RTI_LOG2 = 13,
  parameter int ADDR_W   = 4,
  localparam int FLAG_W  = N_CAP + N_CMP + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_CAP-1:0]  cap_pin,
  output logic [N_CMP-1:0]  cmp_pin,
  output logic [N_CMP-1:0]  cmp_hiz,
  output logic [FLAG_W-1:0] irq
);
  localparam int A_CNT  = 0;
  localparam int A_CAP0 = 1;
  localparam int A_CMP0 = A_CAP0 + N_CAP;
  localparam int A_EDGE = A_CMP0 + N_CMP;
  localparam int A_ACT  = A_EDGE + 1;
  localparam int A_CTL  = A_ACT + 1;
  localparam int A_FLG  = A_CTL + 1;
  localparam int A_EN   = A_FLG + 1;

  // named internal events, visible to the bound checker
  logic                   cnt_tick, cnt_wrap, rti_hit;
  logic [CNT_W-1:0]       count;
  logic [N_CAP-1:0]       cap_hit;
  logic [N_CMP-1:0]       cmp_hit;
  logic [N_CAP*CNT_W-1:0] cap_flat;
  logic [N_CMP*CNT_W-1:0] tgt_flat;
  logic [FLAG_W-1:0]      set_vec, clr_vec;

  logic [CNT_W-1:0]   cap_val [N_CAP];
  logic [CNT_W-1:0]   tgt_q   [N_CMP];
  logic [2*N_CAP-1:0] edge_q;
  logic [2*N_CMP-1:0] act_q;
  logic [3:0]         ctl_q;
  logic [FLAG_W-1:0]  flags_q, en_q;

  tmr_prescale #(.CNT_W(CNT_W), .RTI_LOG2(RTI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .psel(ctl_q[1:0]), .rsel(ctl_q[3:2]),
    .tick(cnt_tick), .wrap(cnt_wrap), .rti_hit(rti_hit), .count(count)
  );

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    tmr_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[c]),
      .edge_sel(edge_q[2*c +: 2]), .count(count),
      .hit(cap_hit[c]), .cap_val(cap_val[c])
    );
    assign cap_flat[c*CNT_W +: CNT_W] = cap_val[c];
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .count(count),
      .target(tgt_q[k]), .act(act_q[2*k +: 2]),
      .hit(cmp_hit[k]), .pin_q(cmp_pin[k]), .hiz(cmp_hiz[k])
    );
    assign tgt_flat[k*CNT_W +: CNT_W] = tgt_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n) tgt_q[k] <= '1;
      else if (bus_wr && bus_addr == ADDR_W'(A_CMP0 + k)) tgt_q[k] <= bus_wdata;
    end
  end

  assign set_vec = {rti_hit, cnt_wrap, cmp_hit, cap_hit};
  assign clr_vec = (bus_wr && bus_addr == ADDR_W'(A_FLG)) ? bus_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q  <= '0;
      act_q   <= '0;
      ctl_q   <= '0;
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (bus_wr) begin
        if (bus_addr == ADDR_W'(A_EDGE)) edge_q <= bus_wdata[2*N_CAP-1:0];
        if (bus_addr == ADDR_W'(A_ACT))  act_q  <= bus_wdata[2*N_CMP-1:0];
        if (bus_addr == ADDR_W'(A_CTL))  ctl_q  <= bus_wdata[3:0];
        if (bus_addr == ADDR_W'(A_EN))   en_q   <= bus_wdata[FLAG_W-1:0];
      end
    end
  end

  assign irq = flags_q & en_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CNT))  bus_rdata = count;
    for (int c = 0; c < N_CAP; c++)
      if (bus_addr == ADDR_W'(A_CAP0 + c)) bus_rdata = cap_val[c];
    for (int k = 0; k < N_CMP; k++)
      if (bus_addr == ADDR_W'(A_CMP0 + k)) bus_rdata = tgt_q[k];
    if (bus_addr == ADDR_W'(A_EDGE)) bus_rdata = CNT_W'(edge_q);
    if (bus_addr == ADDR_W'(A_ACT))  bus_rdata = CNT_W'(act_q);
    if (bus_addr == ADDR_W'(A_CTL))  bus_rdata = CNT_W'(ctl_q);
    if (bus_addr == ADDR_W'(A_FLG))  bus_rdata = CNT_W'(flags_q);
    if (bus_addr == ADDR_W'(A_EN))   bus_rdata = CNT_W'(en_q);
  end
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 3,
  parameter int N_CMP = 5,
  localparam int FLAG_W = N_CAP + N_CMP + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   wrap,
  input logic                   rti_hit,
  input logic [CNT_W-1:0]       count,
  input logic [N_CAP-1:0]       cap_hit,
  input logic [N_CAP*CNT_W-1:0] cap_flat,
  input logic [N_CMP-1:0]       cmp_hit,
  input logic [N_CMP*CNT_W-1:0] tgt_flat,
  input logic [N_CMP-1:0]       cmp_pin,
  input logic [FLAG_W-1:0]      flags
);
  localparam int OVF_B = N_CAP + N_CMP;
  localparam int RTI_B = OVF_B + 1;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + CNT_W'(1)));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[OVF_B]);

  assert_rti_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rti_hit |=> flags[RTI_B]);

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap_chk
    assert_cap_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[c] |=> (cap_flat[c*CNT_W +: CNT_W] == $past(count)) && flags[c]);
    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_hit[c] |=> $stable(cap_flat[c*CNT_W +: CNT_W]));
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp_chk
    assert_cmp_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[k] |=> flags[N_CAP+k] && (count == $past(tgt_flat[k*CNT_W +: CNT_W])));
    assert_pin_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_hit[k] |=> $stable(cmp_pin[k]));
  end
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CNT_W(CNT_W), .N_CAP(N_CAP), .N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .wrap(cnt_wrap), .rti_hit(rti_hit),
  .count(count), .cap_hit(cap_hit), .cap_flat(cap_flat), .cmp_hit(cmp_hit),
  .tgt_flat(tgt_flat), .cmp_pin(cmp_pin), .flags(flags_q)
);

// File: tb/tb_tmr_capcmp.sv
`timescale 1ns/100ps
module tb_tmr_capcmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  cap_pin = '0;
  logic [4:0]  cmp_pin, cmp_hiz;
  logic [9:0]  irq;

  always #2.5 clk = ~clk;

  tmr_capcmp dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .cmp_pin(cmp_pin), .cmp_hiz(cmp_hiz), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pre, m_rti, m_cnt, m_edge, m_act, m_ctl, m_flags, m_en;
  int m_cap[3];
  int m_tgt[5];
  bit [4:0] m_pin;
  bit [2:0] s1, s2, s3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_rti = 0; m_cnt = 0; m_edge = 0; m_act = 0; m_ctl = 0;
      m_flags = 0; m_en = 0; m_pin = '0; s1 = '0; s2 = '0; s3 = '0;
      foreach (m_cap[i]) m_cap[i] = 0;
      foreach (m_tgt[i]) m_tgt[i] = 65535;
    end else begin : upd
      int div, per, nc, setv, clr, sel;
      bit tk, rise, fall;
      case (m_ctl & 3) 0: div = 1; 1: div = 4; 2: div = 8; default: div = 16; endcase
      tk = (m_pre % div) == div - 1;
      nc = tk ? (m_cnt + 1) % 65536 : m_cnt;
      setv = 0;
      if (tk && m_cnt == 65535) setv |= 1 << 8;
      per = 8192 << ((m_ctl >> 2) & 3);
      if ((m_rti % per) == per - 1) setv |= 1 << 9;
      for (int k = 0; k < 5; k++)
        if (tk && nc == m_tgt[k]) begin
          setv |= 1 << (3 + k);
          case ((m_act >> (2 * k)) & 3)
            1: m_pin[k] = ~m_pin[k];
            2: m_pin[k] = 1'b0;
            3: m_pin[k] = 1'b1;
            default: ;
          endcase
        end
      for (int c = 0; c < 3; c++) begin
        sel  = (m_edge >> (2 * c)) & 3;
        rise = s2[c] && !s3[c];
        fall = !s2[c] && s3[c];
        if ((sel == 1 && rise) || (sel == 2 && fall) || (sel == 3 && (rise || fall))) begin
          m_cap[c] = m_cnt;
          setv |= 1 << c;
        end
      end
      clr = (bus_wr && bus_addr == 12) ? int'(bus_wdata) : 0;
      m_flags = ((m_flags & ~clr) | setv) & 1023;
      if (bus_wr) begin
        if (bus_addr >= 4 && bus_addr <= 8) m_tgt[bus_addr - 4] = bus_wdata;
        if (bus_addr == 9)  m_edge = bus_wdata & 63;
        if (bus_addr == 10) m_act  = bus_wdata & 1023;
        if (bus_addr == 11) m_ctl  = bus_wdata & 15;
        if (bus_addr == 13) m_en   = bus_wdata & 1023;
      end
      m_cnt = nc;
      m_pre = (m_pre + 1) % 16;
      m_rti = (m_rti + 1) % 65536;
      s3 = s2; s2 = s1; s1 = cap_pin;
    end
  end

  function automatic int model_rd(input int a);
    if (a == 0) return m_cnt;
    if (a >= 1 && a <= 3) return m_cap[a - 1];
    if (a >= 4 && a <= 8) return m_tgt[a - 4];
    case (a)
      9: return m_edge; 10: return m_act; 11: return m_ctl;
      12: return m_flags; 13: return m_en;
      default: return 0;
    endcase
  endfunction

  function automatic int model_hiz();
    int h = 0;
    for (int k = 0; k < 5; k++) if (((m_act >> (2 * k)) & 3) == 0) h |= 1 << k;
    return h;
  endfunction

  // every-cycle comparison of the outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 irq lines", int'(irq), m_flags & m_en);
      chk("R7 compare pins", int'(cmp_pin), int'(m_pin));
      chk("R7 disconnect", int'(cmp_hiz), model_hiz());
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(posedge clk); #1;
    bus_addr = 4'(a);
    @(negedge clk);
    chk(tag, int'(bus_rdata), model_rd(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_pins(input int v);
    @(posedge clk); #1;
    cap_pin = 3'(v);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired before the sequence ended");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset values, R10 register map
    for (int a = 0; a < 16; a++) rd(a, "R10 reset readback");
    rd(4, "R6 target reset"); chk("R6 target reset literal", int'(bus_rdata), 16'hFFFF);

    // R1 counter cannot be written
    wr(0, 16'h1234);
    rd(0, "R1 counter ignores write");

    // compare actions: ch0 toggle, ch1 clear, ch2 set, ch3 none, ch4 toggle
    wr(13, 10'h3FF);
    wr(10, 16'h0139);
    rd(10, "R10 action readback");
    wr(4, (m_cnt + 60) % 65536);
    wr(5, (m_cnt + 80) % 65536);
    wr(6, (m_cnt + 70) % 65536);
    wr(7, (m_cnt + 90) % 65536);
    wr(8, (m_cnt + 60) % 65536);
    idle(150);
    rd(12, "R6 compare flags");
    chk("R7 pins after first matches", int'(cmp_pin), 5'b10101);
    wr(12, 16'h00F8);
    rd(12, "R9 W1C of compare flags");

    // R2 prescale settings, each with a compare match
    for (int p = 1; p < 4; p++) begin
      wr(11, p);
      rd(11, "R2 control readback");
      wr(4, (m_cnt + 5) % 65536);
      idle(120);
      rd(0, "R2 prescaled count");
      rd(12, "R2 match under prescale");
      wr(12, 16'h03FF);
    end
    wr(11, 0);

    // R4 / R5 captures
    wr(9, 16'h0039);
    set_pins(3'b111); idle(10);
    for (int c = 1; c < 4; c++) rd(c, "R4 capture after rising");
    set_pins(3'b000); idle(10);
    for (int c = 1; c < 4; c++) rd(c, "R4 capture after falling");
    rd(12, "R4 capture flags");
    wr(12, 16'h0007);
    set_pins(3'b101); idle(3); set_pins(3'b010); idle(10);
    for (int c = 1; c < 4; c++) rd(c, "R5 short pulses");
    wr(9, 0);
    wr(12, 16'h0007);
    set_pins(3'b111); idle(10); set_pins(3'b000); idle(10);
    for (int c = 1; c < 4; c++) rd(c, "R5 disabled channel keeps value");
    rd(12, "R5 disabled channel sets no flag");

    // R3 overflow and R8 real-time tick at the fastest rate
    wr(12, 16'h03FF);
    idle(66000);
    rd(12, "R3 R8 flags after a full period");
    chk("R3 overflow flag literal", (int'(bus_rdata) >> 8) & 1, 1);
    chk("R8 real-time flag literal", (int'(bus_rdata) >> 9) & 1, 1);

    // R8 slower rate, clear flags while events keep arriving (R9)
    wr(11, 4'b0100);
    wr(12, 16'h03FF);
    for (int i = 0; i < 8; i++) begin
      idle(4000);
      wr(12, 16'h0200);
      rd(12, "R9 clear during activity");
    end
    wr(13, 16'h0000);
    rd(13, "R9 enables off");
    idle(20);

    summary();
    $finish;
  end
endmodule